// File: doc/BRIEF.md
# Accelerator Bus Speed Arbiter

This block sits between a fast processor and a slow legacy system bus. On every processor access it decodes the address and the read/write direction, picks the memory that will serve it, and decides whether the access can finish in one fast clock or must be held and lined up with the legacy bus phase. Fast accesses go to local static RAM, or to a fast shadow copy of the ROM areas. Slow accesses hold the processor through a ready signal until one complete high phase of the legacy clock has passed. A strobe marks that phase.

The block comes out of reset in an all-slow mode. In this mode ROM reads still go to the original ROM on the legacy bus, and writes into the ROM windows fill the shadow copy. Once boot software has copied the ROMs, it sets the fast bit in a small control register. Setting the force-slow bit in the same register makes every access slow again, for example around timing-sensitive peripheral code. A parameter selects a simpler build in which every write is slow whatever its address. The legacy clock enters as a plain phase signal. It is synchronised into the fast clock domain before edge detection.

Top module: `bus_speed_arbiter`

## Requirements
- R1: In fast mode (control bit 0 set, bit 1 clear), a read or write to local RAM (any address outside the I/O window, the ROM windows and the control address) completes with zero stall cycles, and `mem_target` is 2'b00.
- R2: In fast mode, a read in a ROM window (0xA000–0xBFFF or 0xE000–0xFFFF) completes with zero stall cycles and `mem_target` is 2'b01 (shadow copy). A write in a ROM window always targets 2'b01.
- R3: Any access in the I/O window 0xD000–0xDFFF is slow in every mode, and `mem_target` is 2'b10 (legacy bus).
- R4: With `ALL_WR_SLOW` = 1, every write is slow whatever its address. With `ALL_WR_SLOW` = 0, the direction alone never makes an access slow.
- R5: After reset the control register is 2'b00 and every access is slow. In that mode a ROM-window read targets 2'b10 (original ROM).
- R6: The control register sits at address 0x0002 (`mem_target` 2'b11). A completed write loads bit 0 (fast) and bit 1 (force-slow) from `cpu_wdata_lo`. With bit 1 set, every access is slow even though bit 0 is set. Clearing bit 1 restores fast timing.
- R7: A slow access starts only at a synchronised rising edge of `slow_phase_in` seen after the decode cycle. `slow_strobe` then stays high for the whole synchronised high phase (HALF cycles for a phase of HALF high / HALF low), and `cpu_ready` rises for one cycle right after the strobe falls. With the input sampled at the fast clock, decode in cycle n0 and the first synchronised rise detected in cycle m > n0 give a stall of m + HALF − n0 + 1 cycles.
- R8: In fast mode, an access to the control address completes with zero stall cycles.
- R9: With no access pending, `cpu_ready` is high and `slow_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_phase_in | input | 1 | Legacy bus clock phase, asynchronous to clk |
| cpu_valid | input | 1 | Processor access present; held until cpu_ready |
| cpu_addr | input | AW | Access address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata_lo | input | 2 | Low two data bits, used for control-register writes |
| cpu_ready | output | 1 | Access completes at the next clock edge when high |
| slow_strobe | output | 1 | High while the legacy bus phase of a slow access is running |
| mem_target | output | 2 | Serving memory: 00 RAM, 01 ROM shadow, 10 legacy bus, 11 control register |

## Verification
The decode of a slow access can fall in the same cycle in which the synchroniser reports a rising edge of the legacy phase. The block must ignore that edge and wait a full phase period. The bench sweeps every region, direction and mode, and it inserts a varying number of idle cycles before each access. Its accesses therefore start at every offset of the phase, including the coinciding one. It measures the stall and strobe lengths at the ports and judges them against the closed-form count of R7, computed from its own phase schedule.

// File: rtl/bsa_pkg.sv
// Package: shared types for the bus speed arbiter.
// Assumes a single fast clock domain; encodings here are visible at the ports.
package bsa_pkg;

    // Memory that serves the current access (encoding appears on mem_target).
    typedef enum logic [1:0] {
        TGT_RAM    = 2'b00,
        TGT_SHADOW = 2'b01,
        TGT_LEGACY = 2'b10,
        TGT_CTRL   = 2'b11
    } target_e;

    // Stall sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WAIT   = 2'b01,
        ST_STROBE = 2'b10,
        ST_DONE   = 2'b11
    } stall_state_e;

    // One-hot region hits from the address decoder.
    typedef struct packed {
        logic ctrl;
        logic io;
        logic rom;
        logic ram;
    } region_hit_t;

endpackage

// File: rtl/bsa_phase_sync.sv
// Module: bsa_phase_sync
// Brings the asynchronous legacy phase into the clk domain through a chain of
// STAGES flops, then flags single-cycle rising and falling edges of the
// synchronised level. Assumes the phase is much slower than clk.
module bsa_phase_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_in,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchroniser chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], phase_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Edge flags from the settled level and its history.
    always_comb begin
        rise_o = sync_q[STAGES-1] & ~prev_q;
        fall_o = ~sync_q[STAGES-1] & prev_q;
    end

    // Both edges never flag at once (R7).
    assert_edges_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

    // A rise is followed by no second rise in the next cycle (R7).
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/bsa_addr_decode.sv
// Module: bsa_addr_decode
// Classifies an address into control register, I/O window, ROM window or RAM
// (in that priority) and names the memory that serves it. ROM reads come from
// the shadow copy only once fast mode is on; ROM writes always fill the shadow.
// Assumes ROM windows do not overlap the I/O window.
module bsa_addr_decode
    import bsa_pkg::*;
#(
    parameter int                  AW        = 16,
    parameter int                  ROM_N     = 2,
    parameter logic [ROM_N*AW-1:0] ROM_BASES = {16'hE000, 16'hA000},
    parameter logic [ROM_N*AW-1:0] ROM_LASTS = {16'hFFFF, 16'hBFFF},
    parameter logic [AW-1:0]       IO_BASE   = 16'hD000,
    parameter logic [AW-1:0]       IO_LAST   = 16'hDFFF,
    parameter logic [AW-1:0]       CTRL_ADDR = 16'h0002
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic        rw_i,
    input  logic        fast_en_i,
    output region_hit_t hit_o,
    output target_e     target_o
);

    logic [ROM_N-1:0] rom_win_hit;

    // One comparator pair per ROM window.
    for (genvar gi = 0; gi < ROM_N; gi++) begin : g_rom_win
        always_comb begin
            rom_win_hit[gi] = (addr_i >= ROM_BASES[gi*AW +: AW]) &&
                              (addr_i <= ROM_LASTS[gi*AW +: AW]);
        end
    end

    // Priority region classification.
    always_comb begin
        hit_o      = '0;
        if (addr_i == CTRL_ADDR) begin
            hit_o.ctrl = 1'b1;
        end else if (addr_i >= IO_BASE && addr_i <= IO_LAST) begin
            hit_o.io   = 1'b1;
        end else if (|rom_win_hit) begin
            hit_o.rom  = 1'b1;
        end else begin
            hit_o.ram  = 1'b1;
        end
    end

    // Serving memory for the classified region.
    always_comb begin
        unique case (1'b1)
            hit_o.ctrl: target_o = TGT_CTRL;
            hit_o.io:   target_o = TGT_LEGACY;
            hit_o.rom:  target_o = (rw_i && !fast_en_i) ? TGT_LEGACY : TGT_SHADOW;
            default:    target_o = TGT_RAM;
        endcase
    end

    // Exactly one region is hit for every address (R1).
    assert_one_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(hit_o));

endmodule

// File: rtl/bsa_speed_ctrl.sv
// Module: bsa_speed_ctrl
// Holds the two-bit speed control register: bit 0 enables fast mode, bit 1
// forces every access slow. Loads only on a completed write to its address.
// Resets to all-slow with fast mode cleared.
module bsa_speed_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_commit_i,
    input  logic [1:0] wdata_i,
    output logic       fast_en_o,
    output logic       force_slow_o
);

    // Control register update on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_en_o    <= 1'b0;
            force_slow_o <= 1'b0;
        end else if (wr_commit_i) begin
            fast_en_o    <= wdata_i[0];
            force_slow_o <= wdata_i[1];
        end
    end

    // Leaving reset always starts in slow mode (R5).
    assert_reset_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!fast_en_o && !force_slow_o));

    // The register changes only after a committed write (R6).
    assert_ctrl_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit_i |=> $stable({fast_en_o, force_slow_o}));

endmodule

// File: rtl/bsa_stall_fsm.sv
// Module: bsa_stall_fsm
// Sequences one slow access: after the decode cycle it waits for a
// synchronised phase rise, runs the strobe through the high phase, and on the
// fall releases ready for exactly one cycle. Fast accesses pass straight
// through in the idle state. Assumes the processor holds its request until ready.
module bsa_stall_fsm
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic need_slow_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic ready_o,
    output logic strobe_o
);

    stall_state_e state_q;
    stall_state_e state_d;

    // Next-state selection for the slow-access sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (valid_i && need_slow_i) state_d = ST_WAIT;
            ST_WAIT:   if (rise_i)                 state_d = ST_STROBE;
            ST_STROBE: if (fall_i)                 state_d = ST_DONE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Handshake outputs from the state.
    always_comb begin
        ready_o  = ((state_q == ST_IDLE) && !(valid_i && need_slow_i)) ||
                   (state_q == ST_DONE);
        strobe_o = (state_q == ST_STROBE);
    end

    // The release cycle lasts exactly one clock (R7).
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_IDLE));

    // The strobe starts only after a synchronised rise (R7).
    assert_strobe_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> $past(rise_i));

    // The strobe ends on a synchronised fall and hands over to ready (R7).
    assert_strobe_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_o) |-> ($past(fall_i) && ready_o));

    // Ready and strobe are never high together (R7).
    assert_strobe_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> !ready_o);

endmodule

// File: rtl/bus_speed_arbiter.sv
// Module: bus_speed_arbiter (top)
// Decides per processor access whether it finishes at full speed from local
// RAM or the ROM shadow, or is held and aligned to the legacy bus phase.
// Assumes cpu_addr, cpu_rw and cpu_wdata_lo stay stable while cpu_valid is
// high and cpu_ready is low, and that slow_phase_in is far slower than clk.
module bus_speed_arbiter
    import bsa_pkg::*;
#(
    parameter int              AW          = 16,
    parameter int              SYNC_STAGES = 2,
    parameter bit              ALL_WR_SLOW = 1'b0,
    parameter logic [AW-1:0]   IO_BASE     = 16'hD000,
    parameter logic [AW-1:0]   IO_LAST     = 16'hDFFF,
    parameter logic [AW-1:0]   CTRL_ADDR   = 16'h0002,
    parameter int              ROM_N       = 2,
    parameter logic [ROM_N*AW-1:0] ROM_BASES = {16'hE000, 16'hA000},
    parameter logic [ROM_N*AW-1:0] ROM_LASTS = {16'hFFFF, 16'hBFFF}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_phase_in,
    input  logic          cpu_valid,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rw,
    input  logic [1:0]    cpu_wdata_lo,
    output logic          cpu_ready,
    output logic          slow_strobe,
    output logic [1:0]    mem_target
);

    region_hit_t hit;
    target_e     target;
    logic        fast_en;
    logic        force_slow;
    logic        need_slow;
    logic        ctrl_commit;
    logic        phase_rise;
    logic        phase_fall;

    bsa_phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (slow_phase_in),
        .rise_o   (phase_rise),
        .fall_o   (phase_fall)
    );

    bsa_addr_decode #(
        .AW        (AW),
        .ROM_N     (ROM_N),
        .ROM_BASES (ROM_BASES),
        .ROM_LASTS (ROM_LASTS),
        .IO_BASE   (IO_BASE),
        .IO_LAST   (IO_LAST),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (cpu_addr),
        .rw_i      (cpu_rw),
        .fast_en_i (fast_en),
        .hit_o     (hit),
        .target_o  (target)
    );

    bsa_speed_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_commit_i  (ctrl_commit),
        .wdata_i      (cpu_wdata_lo),
        .fast_en_o    (fast_en),
        .force_slow_o (force_slow)
    );

    // Slow decision: mode, I/O window, and optionally every write.
    always_comb begin
        need_slow = !fast_en || force_slow || hit.io || (ALL_WR_SLOW && !cpu_rw);
    end

    // A control write takes effect when its access completes.
    always_comb begin
        ctrl_commit = cpu_valid && cpu_ready && !cpu_rw && hit.ctrl;
    end

    bsa_stall_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (cpu_valid),
        .need_slow_i (need_slow),
        .rise_i      (phase_rise),
        .fall_i      (phase_fall),
        .ready_o     (cpu_ready),
        .strobe_o    (slow_strobe)
    );

    // Drive the target code onto the port.
    always_comb begin
        mem_target = target;
    end

    // A legacy-bus access completes only after a strobe phase (R3).
    assert_legacy_strobed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && (mem_target == TGT_LEGACY)) |-> $past(slow_strobe));

    // In force-slow mode every completion follows a strobe phase (R6).
    assert_force_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_slow && cpu_valid && cpu_ready) |-> $past(slow_strobe));

    // Fast-mode RAM and shadow accesses never stall (R1).
    assert_fast_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !$past(cpu_valid) && fast_en && !force_slow && !hit.io &&
         (cpu_rw || !ALL_WR_SLOW)) |-> cpu_ready);

    // With no access pending the port is quiet (R9).
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_valid && !$past(cpu_valid)) |-> (cpu_ready && !slow_strobe));

    // Simplified build: every write waits for the legacy phase (R4).
    if (ALL_WR_SLOW) begin : g_all_wr_chk
        assert_write_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid && cpu_ready && !cpu_rw) |-> $past(slow_strobe));
    end

endmodule

// File: tb/bus_speed_arbiter_tb.sv
// Bench: sweeps regions, directions and modes on two builds (ALL_WR_SLOW 0
// and 1) at varying phase offsets; stall counts are computed from the bench's
// own legacy phase schedule.
module bus_speed_arbiter_tb;

    localparam int HALF = 3;          // legacy phase: HALF high, HALF low
    localparam int PER  = 2 * HALF;
    localparam logic [15:0] CTRL = 16'h0002;

    logic clk = 1'b0;
    always #5 clk = ~clk;             // 100 MHz

    logic        rst_n = 1'b0;
    logic        phase = 1'b0;
    int          ecnt  = 0;
    logic [15:0] addr  = '0;
    logic        rw    = 1'b1;
    logic [1:0]  wdata = '0;
    logic        valid0 = 1'b0, valid1 = 1'b0;
    logic        ready0, ready1, strobe0, strobe1;
    logic [1:0]  tgt0, tgt1;

    int checks = 0;
    int errors = 0;
    bit fast_m [2];
    bit force_m [2];

    bus_speed_arbiter #(.ALL_WR_SLOW(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .slow_phase_in(phase), .cpu_valid(valid0),
        .cpu_addr(addr), .cpu_rw(rw), .cpu_wdata_lo(wdata),
        .cpu_ready(ready0), .slow_strobe(strobe0), .mem_target(tgt0));

    bus_speed_arbiter #(.ALL_WR_SLOW(1'b1)) u_dut_wr (
        .clk(clk), .rst_n(rst_n), .slow_phase_in(phase), .cpu_valid(valid1),
        .cpu_addr(addr), .cpu_rw(rw), .cpu_wdata_lo(wdata),
        .cpu_ready(ready1), .slow_strobe(strobe1), .mem_target(tgt1));

    always @(posedge clk) ecnt <= ecnt + 1;
    always @(negedge clk) phase = ((ecnt % PER) >= HALF);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d addr=%h rw=%0d", req, act, exp, addr, rw);
        end
    endtask

    function automatic int exp_stall(input int n0);
        int m = n0 + 1;
        while ((m % PER) != ((HALF + 2) % PER)) m++;
        return m + HALF - n0 + 1;
    endfunction

    function automatic bit is_io(input logic [15:0] a);
        return a >= 16'hD000 && a <= 16'hDFFF;
    endfunction

    function automatic bit is_rom(input logic [15:0] a);
        return (a >= 16'hA000 && a <= 16'hBFFF) || a >= 16'hE000;
    endfunction

    function automatic int exp_tgt(input logic [15:0] a, input bit r, input bit f);
        if (a == CTRL) return 3;
        if (is_io(a))  return 2;
        if (is_rom(a)) return (r && !f) ? 2 : 1;
        return 0;
    endfunction

    // One access on instance w; called just after a falling edge.
    task automatic access(input int w, input logic [15:0] a, input bit r, input logic [1:0] d);
        int stalls = 0, strobes = 0, tg = 0, n0;
        bit slow, rd, st;
        string req;
        slow = !fast_m[w] || force_m[w] || is_io(a) || (w == 1 && !r);
        addr = a; rw = r; wdata = d; n0 = ecnt;
        if (w == 0) valid0 = 1'b1; else valid1 = 1'b1;
        forever begin
            #1;
            rd = (w == 0) ? ready0 : ready1;
            st = (w == 0) ? strobe0 : strobe1;
            tg = (w == 0) ? int'(tgt0) : int'(tgt1);
            if (st) strobes++;
            if (rd) break;
            stalls++;
            @(negedge clk);
        end
        if (is_io(a))                 req = "R3";
        else if (!fast_m[w])          req = "R5";
        else if (force_m[w])          req = "R6";
        else if (w == 1 && !r)        req = "R4";
        else if (a == CTRL)           req = "R8";
        else if (is_rom(a))           req = "R2";
        else                          req = "R1";
        check(stalls == (slow ? exp_stall(n0) : 0), req, stalls, slow ? exp_stall(n0) : 0);
        check(strobes == (slow ? HALF : 0), "R7 strobe length", strobes, slow ? HALF : 0);
        check(tg == exp_tgt(a, r, fast_m[w]),
              (a == CTRL) ? "R6 target" : (is_io(a) ? "R3 target" :
              (is_rom(a) ? (fast_m[w] ? "R2 target" : "R5 target") : "R1 target")),
              tg, exp_tgt(a, r, fast_m[w]));
        if (r == 1'b0 && a == CTRL) begin
            fast_m[w]  = d[0];
            force_m[w] = d[1];
        end
        @(negedge clk);
        valid0 = 1'b0; valid1 = 1'b0;
        #1;
        rd = (w == 0) ? ready0 : ready1;
        st = (w == 0) ? strobe0 : strobe1;
        check(rd && !st, "R9 idle", {rd, st}, 2);
        @(negedge clk);
    endtask

    localparam logic [15:0] ADDRS [13] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
        16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hCFFF, 16'hD000, 16'hDFFF,
        16'hE000, 16'hFFFF};
    localparam logic [1:0] MODES [4] = '{2'b00, 2'b01, 2'b11, 2'b01};

    initial begin
        int idx = 0;
        fast_m = '{0, 0};
        force_m = '{0, 0};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        #1;
        check(ready0 && !strobe0, "R9 reset state", {ready0, strobe0}, 2);
        check(ready1 && !strobe1, "R9 reset state", {ready1, strobe1}, 2);
        @(negedge clk);
        for (int w = 0; w < 2; w++) begin
            for (int mi = 0; mi < 4; mi++) begin
                if (mi != 0) access(w, CTRL, 1'b0, MODES[mi]);   // R6 mode write
                for (int ai = 0; ai < 13; ai++) begin
                    for (int r = 1; r >= 0; r--) begin
                        if (!(ADDRS[ai] == CTRL && r == 0)) begin
                            repeat (idx % PER) @(negedge clk);
                            idx++;
                            access(w, ADDRS[ai], r[0], 2'b00);
                        end
                    end
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=0", ecnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule